// File: doc/BRIEF.md
# Poly1305 Message Authenticator Engine

This block computes the 128-bit Poly1305 authentication tag of a message whose byte length is known before the run begins. A 256-bit one-time key and the length are presented together with a start pulse. The engine splits the key into a multiplier half and a final-offset half, and clamps the multiplier half. It then requests the message one 16-byte chunk at a time, lowest chunk first.

Each chunk is read as a little-endian integer. Bytes at or beyond the remaining length are discarded, and a single 1 bit is set just above the last valid byte. The padded value is added to a 130-bit accumulator, and the sum is multiplied by the clamped half modulo 2^130-5. The multiply is a bit-serial double-add-reduce scan that retires one multiplier bit per clock. After the last chunk, the offset half is added and the low 128 bits are presented as the tag, with a one-cycle done pulse.

Deriving the one-time key and assembling the authenticated-encryption input are left to the surrounding logic.

Top module: `poly_mac_core`

## Requirements
- R1: The low 128 bits of `key` form the multiplier r, ANDed with 0x0ffffffc0ffffffc0ffffffc0fffffff. The high 128 bits form the offset s.
- R2: Full 16-byte chunks are taken in order, with byte k of a chunk at bits [8k+7:8k]. Each chunk becomes the block value (chunk + 2^128), and the accumulator (starting at 0) is updated as acc = ((acc + block) * r) mod (2^130-5).
- R3: A final partial chunk of n bytes (1..15) uses only its bytes 0..n-1. The bytes above are ignored whatever their value, and the block is that value plus 2^(8n).
- R4: A message length of 0 requests no chunk and yields a tag equal to s.
- R5: `tag` equals the low 128 bits of (acc + s), with tag byte 0 at bits [7:0].
- R6: `busy` rises only in the cycle after an accepted `start`. `done` is high for exactly one cycle, in which `busy` is already low.
- R7: A chunk is consumed only in a cycle where both `chunk_req` and `chunk_valid` are high. `chunk_req` stays high until that happens and is never high while idle. Exactly ceil(length/16) chunks are consumed.
- R8: `start` while `busy` is high is ignored: the running key, length and tag are unaffected.
- R9: The stored accumulator is always below 2^130-5.
- R10: After reset, `busy`, `done`, `chunk_req` and `tag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with `key` and `msg_len` (accepted while idle) |
| key | input | 256 | One-time key: r in [127:0], s in [255:128] |
| msg_len | input | LEN_W (16) | Message length in bytes |
| chunk_req | output | 1 | Engine is waiting for the next chunk |
| chunk_valid | input | 1 | `chunk_data` holds the requested chunk |
| chunk_data | input | 128 | Message chunk, byte 0 in [7:0] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: `tag` is valid |
| tag | output | 128 | Authentication tag, byte 0 in [7:0] |

## Verification
The bench aims at the lengths where padding is easy to misplace: 0, 1, 5, 15, 16, 17 and a multi-chunk tail. A pad placed at a fixed position, or garbage left in unused bytes, would change the tag. An all-ones key drives the accumulator near the modulus and checks the clamp. Missing the clamp, or a single missing conditional subtract in the double or the add, would give a wrong tag.

Extra `start` pulses in the middle of a run, spurious `chunk_valid` while no request is open, and stalls in the chunk supply are all applied. A design that restarted, consumed an unrequested chunk, or lost a chunk during a stall would give a wrong tag or a wrong count of consumed chunks.

// File: rtl/poly_pkg.sv
// Shared constants, state encoding and the single-step modular fold used
// by the Poly1305 engine. Assumes operands to fold_once are below 2*P.
package poly_pkg;
    localparam int ACC_W = 130;
    localparam int R_W   = 128;
    localparam logic [ACC_W-1:0] P_MOD = 130'h3_ffffffff_ffffffff_ffffffff_fffffffb;
    localparam logic [R_W-1:0]   R_CLAMP = 128'h0ffffffc_0ffffffc_0ffffffc_0fffffff;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_MUL  = 2'd2
    } eng_state_t;

    // Subtract the modulus once if the value is at or above it.
    function automatic logic [ACC_W-1:0] fold_once(input logic [ACC_W:0] x);
        logic [ACC_W:0] diff;
        diff = x - {1'b0, P_MOD};
        return (x >= {1'b0, P_MOD}) ? diff[ACC_W-1:0] : x[ACC_W-1:0];
    endfunction
endpackage

// File: rtl/poly_block_former.sv
// Turns a raw chunk into a padded Poly1305 block. Bytes at or above
// nbytes are zeroed and byte position nbytes receives 0x01 (position CB
// is the extra top bit). Assumes nbytes is between 1 and CB.
module poly_block_former #(
    parameter int CB   = 16,
    localparam int NB_W = $clog2(CB + 1)
) (
    input  logic [8*CB-1:0] data,
    input  logic [NB_W-1:0] nbytes,
    output logic [8*CB:0]   blk
);
    for (genvar i = 0; i < CB; i++) begin : g_byte
        localparam logic [NB_W-1:0] IDX = NB_W'(i);
        // Keep a valid byte, place the pad byte, or clear the byte.
        assign blk[8*i +: 8] = (nbytes > IDX) ? data[8*i +: 8]
                                              : {7'b0, (nbytes == IDX)};
    end
    // Pad bit for a full chunk.
    assign blk[8*CB] = (nbytes == NB_W'(CB));
endmodule

// File: rtl/poly_dar_mul.sv
// Bit-serial modular multiplier: prod = a * b mod P, scanning b from its
// top bit down, one bit per clock (double, then conditionally add).
// Assumes a < P. done pulses one cycle after the last step with prod valid.
module poly_dar_mul
    import poly_pkg::*;
#(
    parameter int BW = 128,
    localparam int CNT_W = $clog2(BW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [ACC_W-1:0] a,
    input  logic [BW-1:0]    b,
    output logic             done,
    output logic [ACC_W-1:0] prod
);
    logic [ACC_W-1:0] a_q, prod_q, dbl, addv, nxt;
    logic [BW-1:0]    b_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;

    // One scan step: double modulo P, then add a modulo P on a 1 bit.
    always_comb begin
        dbl  = fold_once({prod_q, 1'b0});
        addv = fold_once({1'b0, dbl} + {1'b0, a_q});
        nxt  = b_q[BW-1] ? addv : dbl;
    end

    // Operand capture, step sequencing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            prod_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (go) begin
            a_q    <= a;
            b_q    <= b;
            prod_q <= '0;
            cnt_q  <= CNT_W'(BW - 1);
            run_q  <= 1'b1;
            done_q <= 1'b0;
        end else if (run_q) begin
            prod_q <= nxt;
            b_q    <= b_q << 1;
            if (cnt_q == '0) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign prod = prod_q;
endmodule

// File: rtl/poly_mac_core.sv
// Poly1305 tag engine. Captures and clamps the key on start, requests
// 16-byte chunks until the byte count is used up, folds each padded
// block into the accumulator through the serial multiplier, then adds
// s to form the tag. Assumes key and msg_len are stable in the start cycle.
module poly_mac_core
    import poly_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CB    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [255:0]     key,
    input  logic [LEN_W-1:0] msg_len,
    output logic             chunk_req,
    input  logic             chunk_valid,
    input  logic [8*CB-1:0]  chunk_data,
    output logic             busy,
    output logic             done,
    output logic [R_W-1:0]   tag
);
    localparam int NB_W = $clog2(CB + 1);

    eng_state_t       state_q;
    logic [R_W-1:0]   r_q, s_q, tag_q;
    logic [ACC_W-1:0] acc_q, sum;
    logic [LEN_W-1:0] rem_q;
    logic [NB_W-1:0]  nbytes;
    logic [8*CB:0]    blk;
    logic             take, done_q, mul_done;
    logic [ACC_W-1:0] mul_prod;

    // Byte count of the chunk being taken, capped at a full chunk.
    always_comb begin
        nbytes = (rem_q >= LEN_W'(CB)) ? NB_W'(CB) : rem_q[NB_W-1:0];
        take   = (state_q == ST_REQ) && chunk_valid;
        sum    = fold_once({1'b0, acc_q} + {{(ACC_W-8*CB-1){1'b0}}, blk});
    end

    poly_block_former #(.CB(CB)) u_blk (
        .data   (chunk_data),
        .nbytes (nbytes),
        .blk    (blk)
    );

    poly_dar_mul #(.BW(R_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (take),
        .a     (sum),
        .b     (r_q),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    // Run control: key capture, chunk intake, accumulator and tag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            r_q     <= '0;
            s_q     <= '0;
            acc_q   <= '0;
            rem_q   <= '0;
            tag_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    r_q   <= key[R_W-1:0] & R_CLAMP;
                    s_q   <= key[255:R_W];
                    acc_q <= '0;
                    rem_q <= msg_len;
                    if (msg_len == '0) begin
                        tag_q  <= key[255:R_W];
                        done_q <= 1'b1;
                    end else begin
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: if (take) begin
                    rem_q   <= rem_q - {{(LEN_W-NB_W){1'b0}}, nbytes};
                    state_q <= ST_MUL;
                end
                ST_MUL: if (mul_done) begin
                    acc_q <= mul_prod;
                    if (rem_q == '0) begin
                        tag_q   <= mul_prod[R_W-1:0] + s_q;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_REQ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign chunk_req = (state_q == ST_REQ);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign tag       = tag_q;
endmodule

// File: rtl/poly_mac_checker.sv
// Protocol and range properties of the Poly1305 engine, bound to the top.
module poly_mac_checker
    import poly_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             chunk_valid,
    input logic             chunk_req,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] acc_q
);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_req |-> busy);
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_req && !chunk_valid) |=> chunk_req);
    a_r9_acc_below_p: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < P_MOD);
endmodule

bind poly_mac_core poly_mac_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .chunk_valid (chunk_valid),
    .chunk_req   (chunk_req),
    .busy        (busy),
    .done        (done),
    .acc_q       (acc_q)
);

// File: tb/poly_mac_core_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural big-integer model computes each tag;
// per-clock checks watch the request and done protocol.
module poly_mac_core_tb_top;
    localparam logic [127:0] CLAMP = 128'h0ffffffc_0ffffffc_0ffffffc_0fffffff;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] key = '0;
    logic [15:0]  msg_len = '0;
    logic         chunk_req;
    logic         chunk_valid = 1'b0;
    logic [127:0] chunk_data = '0;
    logic         busy, done;
    logic [127:0] tag;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [127:0] msg [0:7];

    always #5 clk = ~clk;

    poly_mac_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .msg_len(msg_len),
        .chunk_req(chunk_req), .chunk_valid(chunk_valid), .chunk_data(chunk_data),
        .busy(busy), .done(done), .tag(tag)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", 256'(cycles), 256'd150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Per-clock protocol model: requests and done only in their allowed states.
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(chunk_req && !busy), "R7 request while idle", 256'(chunk_req), 256'(0));
            check(!(done && busy), "R6 busy during done", 256'(busy), 256'(0));
        end
    end

    function automatic logic [127:0] ref_tag(input logic [255:0] k, input int len);
        logic [259:0] acc, r, blk, pp, sum;
        int rem, blen, idx;
        pp  = (260'd1 << 130) - 260'd5;
        r   = {132'd0, k[127:0] & CLAMP};
        acc = '0;
        rem = len;
        idx = 0;
        while (rem > 0) begin
            blen = (rem > 16) ? 16 : rem;
            blk = '0;
            for (int b = 0; b < blen; b++) blk[8*b +: 8] = msg[idx][8*b +: 8];
            blk[8*blen] = 1'b1;
            acc = ((acc + blk) * r) % pp;
            rem -= blen;
            idx++;
        end
        sum = acc + {132'd0, k[255:128]};
        return sum[127:0];
    endfunction

    // One run: stall inserts gaps in chunk supply, poke>=0 fires a stray start.
    task automatic run_msg(input logic [255:0] k, input int len, input bit stall,
                           input int poke, input string req);
        int nreq = 0;
        int cyc = 0;
        bit got = 0;
        bit vld;
        logic [127:0] exp_tag, got_tag;
        exp_tag = ref_tag(k, len);
        @(negedge clk);
        key = k; msg_len = 16'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (len > 0) check(busy == 1'b1, "R6 busy after start", 256'(busy), 256'(1));
        while (!got && cyc < 5000) begin
            if (done) begin
                got = 1;
                got_tag = tag;
                check(busy == 1'b0, "R6 idle at done", 256'(busy), 256'(0));
            end else begin
                vld = !(stall && (cyc % 3 == 0));
                chunk_valid = vld;
                chunk_data  = (chunk_req && vld) ? msg[nreq] : 128'hdead_beef_0bad_f00d_5a5a_a5a5_1234_5678;
                if (poke >= 0 && cyc == poke) begin
                    start = 1'b1; key = ~k; msg_len = 16'd3;
                end else begin
                    start = 1'b0;
                end
                if (chunk_req && vld) nreq++;
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        chunk_valid = 1'b0;
        check(got, {req, " done seen"}, 256'(got), 256'(1));
        check(got_tag == exp_tag, {req, " tag"}, 256'(got_tag), 256'(exp_tag));
        check(nreq == (len + 15) / 16, "R7 chunk count", 256'(nreq), 256'((len + 15) / 16));
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", 256'(done), 256'(0));
    endtask

    initial begin
        logic [255:0] k1, k2, k3;
        for (int i = 0; i < 8; i++) msg[i] = {$urandom, $urandom, $urandom, $urandom};
        k1 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        k2 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        k3 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        repeat (3) @(negedge clk);
        // R10: reset state.
        check(busy == 1'b0, "R10 busy", 256'(busy), 256'(0));
        check(done == 1'b0, "R10 done", 256'(done), 256'(0));
        check(chunk_req == 1'b0, "R10 chunk_req", 256'(chunk_req), 256'(0));
        check(tag == '0, "R10 tag", 256'(tag), 256'(0));
        rst_n = 1'b1;
        // R7: valid data while idle is not consumed.
        @(negedge clk);
        chunk_valid = 1'b1; chunk_data = msg[0];
        repeat (4) @(negedge clk);
        check(chunk_req == 1'b0 && busy == 1'b0, "R7 idle ignores valid", 256'(busy), 256'(0));
        chunk_valid = 1'b0;

        run_msg(k1, 0, 0, -1, "R4 zero length");
        run_msg(k1, 16, 0, -1, "R2 one full chunk");
        run_msg(k2, 32, 1, -1, "R2 two chunks stalled");
        run_msg(k1, 5, 0, -1, "R3 five bytes");
        run_msg(k3, 1, 0, -1, "R3 one byte");
        run_msg(k2, 15, 0, -1, "R3 fifteen bytes");
        run_msg(k1, 17, 1, -1, "R3 seventeen bytes");
        run_msg({256{1'b1}}, 71, 0, -1, "R1 R9 all-ones key");
        run_msg(k3, 100, 0, 50, "R8 stray start");
        run_msg(k2, 48, 0, -1, "R5 tag byte order");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule